// File: doc/BRIEF.md
# USB Endpoint Transaction Responder

This block is the endpoint-side decision stage of a low-speed USB serial interface engine. Upstream logic has already decoded tokens, framed the data packet, counted its bytes and checked its CRC and PID. This block receives those results as single-cycle events. For each transaction it decides whether to answer and which handshake to give. It then updates the endpoint's PID status bits, its count register and its mode, and raises an interrupt request toward the CPU.

Any transaction that fails a check gets no answer at all. The block sends no handshake, raises no interrupt, and leaves every register as it was. An acknowledged transaction moves the endpoint to NAK in hardware and sets a lock. The lock blocks CPU writes to the mode and count registers until the firmware has read one of them after the transaction has finished. Firmware therefore always sees the change the hardware made before it can overwrite it.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset the mode register reads 0x00 (endpoint disabled, status bits clear, unlocked), the count register reads 0x00, and `hs_o`, `tx_data_o` and `irq_o` are low.
- R2: A data packet is accepted only when `rx_cnt_i` (CRC bytes included) is at most 10 and `crc_ok_i` and `pid_ok_i` are both high. When any of these fails, the transaction gets no handshake and no interrupt, and the mode, status and count registers do not change.
- R3: A Setup token (`tok_pid_i` = 1) is answered only when the mode is control (4'h5). In every other mode, the Setup token and its data packet are ignored.
- R4: An In token (`tok_pid_i` = 2) is ignored in accept-Out mode (4'h9) and in disabled mode (4'h0). An Out token (`tok_pid_i` = 3) is ignored in send-In mode (4'hD) and in disabled mode. Codes other than the six defined ones behave as disabled.
- R5: The `hs_o` codes are 1 ACK, 2 NAK and 3 STALL, each driven one cycle after the deciding event. For a valid Out packet the answer is ACK in accept-Out mode, NAK in NAK (4'h1) or control mode, and STALL in stall mode (4'h3). For an In token, send-In mode pulses `tx_data_o` and waits for `host_ack_i`; NAK and control modes answer NAK; stall mode answers STALL.
- R6: `irq_o` pulses for one cycle after every answered transaction ends, and after every `buf_bad_i` pulse. It does not pulse at any other time.
- R7: The In and Out status bits are set when an answered transaction of that direction ends. The Setup status bit is set when the data phase of an accepted Setup begins.
- R8: When an ACK is transferred, the mode becomes NAK (4'h1). After an acknowledged Out or Setup, the count register holds the byte count, the data-valid bit is set and the data-toggle bit is copied from the packet.
- R9: Every transaction in which an ACK is transferred sets the lock. An In transaction transfers its ACK when `host_ack_i` arrives.
- R10: While locked, CPU writes to either register are dropped and leave both registers as they were.
- R11: A CPU read of either register clears the lock, but only while no transaction is in progress. A read made during a transaction leaves the lock set.
- R12: Layout of the mode register: [3:0] mode, [4] Setup status, [5] In status, [6] Out status, [7] lock (read-only). Layout of the count register: [3:0] byte count, [6] data valid, [7] data toggle. `cpu_sel_i` 0 selects the mode register and 1 selects the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_pid_i | input | 2 | Token event: 0 none, 1 Setup, 2 In, 3 Out |
| data_start_i | input | 1 | Pulse at the start of a data packet |
| data_end_i | input | 1 | Pulse at the end of a data packet, carrying the check results |
| rx_cnt_i | input | 4 | Bytes received, CRC included |
| crc_ok_i | input | 1 | CRC check passed |
| pid_ok_i | input | 1 | PID check passed |
| rx_tog_i | input | 1 | Data toggle of the received packet |
| host_ack_i | input | 1 | Host acknowledged the In data |
| buf_bad_i | input | 1 | Receive buffer flagged corrupted |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_re_i | input | 1 | CPU read strobe |
| cpu_sel_i | input | 1 | Register select |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data of the selected register |
| hs_o | output | 2 | Handshake to send |
| tx_data_o | output | 1 | Send the In data packet |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench probes the byte-count boundary with counts of 10 and 11, and also sends packets with bad CRC and bad PID. A design that checked the limit with the wrong comparison, or acted on failed packets, would acknowledge packets it should drop or change registers that must stay put. It sends Setup, In and Out tokens to endpoints configured for the wrong direction or type, where a faulty decode would answer a token it should ignore. The main target is the interlock. The bench attempts CPU writes after the hardware has moved the mode from accept-Out to NAK, reads during an open transaction, and then writes again. A lock that released early, or that ignored reads of the count register, would let firmware overwrite the hardware's change unseen or stay stuck.

// File: rtl/usb_ep_pkg.sv
`timescale 1ns/1ps
package usb_ep_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_DIS   = 4'h0;
  localparam logic [MODE_W-1:0] MODE_NAK   = 4'h1;
  localparam logic [MODE_W-1:0] MODE_STALL = 4'h3;
  localparam logic [MODE_W-1:0] MODE_CTRL  = 4'h5;
  localparam logic [MODE_W-1:0] MODE_RX    = 4'h9;
  localparam logic [MODE_W-1:0] MODE_TX    = 4'hD;

  typedef enum logic [1:0] {TOK_NONE, TOK_SETUP, TOK_IN, TOK_OUT} tok_e;
  typedef enum logic [1:0] {HS_NONE, HS_ACK, HS_NAK, HS_STALL} hs_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT_DATA, S_RX, S_WAIT_HACK} seq_state_e;

  typedef struct packed {
    logic out_st;
    logic in_st;
    logic setup_st;
  } pid_mark_t;

  localparam logic SEL_MODE = 1'b0;
  localparam logic SEL_CNT  = 1'b1;
endpackage

// File: rtl/usb_ep_decide.sv
`timescale 1ns/1ps
module usb_ep_decide
  import usb_ep_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  tok_e              tok_i,
  output hs_e               plan_o
);
  // HS_NONE means the token is ignored
  always_comb begin
    plan_o = HS_NONE;
    unique case (tok_i)
      TOK_SETUP: if (mode_i == MODE_CTRL) plan_o = HS_ACK;
      TOK_IN: begin
        unique case (mode_i)
          MODE_NAK, MODE_CTRL: plan_o = HS_NAK;
          MODE_STALL:          plan_o = HS_STALL;
          MODE_TX:             plan_o = HS_ACK;
          default:             plan_o = HS_NONE;
        endcase
      end
      TOK_OUT: begin
        unique case (mode_i)
          MODE_NAK, MODE_CTRL: plan_o = HS_NAK;
          MODE_STALL:          plan_o = HS_STALL;
          MODE_RX:             plan_o = HS_ACK;
          default:             plan_o = HS_NONE;
        endcase
      end
      default: plan_o = HS_NONE;
    endcase
  end
endmodule

// File: rtl/usb_ep_rxcheck.sv
`timescale 1ns/1ps
module usb_ep_rxcheck #(
  parameter int CNT_W     = 4,
  parameter int MAX_BYTES = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             crc_ok_i,
  input  logic             pid_ok_i,
  output logic             ok_o
);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_BYTES);

  assign ok_o = (cnt_i <= MaxCnt) && crc_ok_i && pid_ok_i;
endmodule

// File: rtl/usb_ep_seq.sv
`timescale 1ns/1ps
module usb_ep_seq
  import usb_ep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tok_e              tok_i,
  input  logic              dstart_i,
  input  logic              dend_i,
  input  logic              pkt_ok_i,
  input  logic              host_ack_i,
  input  logic [MODE_W-1:0] mode_i,
  output hs_e               hs_nx_o,
  output logic              tx_nx_o,
  output logic              done_nx_o,
  output logic              ack_nx_o,
  output logic              cnt_load_o,
  output pid_mark_t         mark_o,
  output logic              in_txn_o
);
  seq_state_e state_q, state_d;
  hs_e        plan_q, plan_d, plan;
  tok_e       tok_q, tok_d;

  usb_ep_decide i_decide (
    .mode_i (mode_i),
    .tok_i  (tok_i),
    .plan_o (plan)
  );

  always_comb begin
    state_d    = state_q;
    plan_d     = plan_q;
    tok_d      = tok_q;
    hs_nx_o    = HS_NONE;
    tx_nx_o    = 1'b0;
    done_nx_o  = 1'b0;
    ack_nx_o   = 1'b0;
    cnt_load_o = 1'b0;
    mark_o     = '0;
    if (tok_i != TOK_NONE) begin
      // a new token always abandons whatever was open
      state_d = S_IDLE;
      if (plan != HS_NONE) begin
        if (tok_i == TOK_IN) begin
          if (plan == HS_ACK) begin
            tx_nx_o = 1'b1;
            state_d = S_WAIT_HACK;
          end else begin
            hs_nx_o      = plan;
            done_nx_o    = 1'b1;
            mark_o.in_st = 1'b1;
          end
        end else begin
          state_d = S_WAIT_DATA;
          plan_d  = plan;
          tok_d   = tok_i;
        end
      end
    end else begin
      unique case (state_q)
        S_WAIT_DATA: if (dstart_i) begin
          state_d         = S_RX;
          mark_o.setup_st = (tok_q == TOK_SETUP);
        end
        S_RX: if (dend_i) begin
          state_d = S_IDLE;
          if (pkt_ok_i) begin
            hs_nx_o       = plan_q;
            done_nx_o     = 1'b1;
            mark_o.out_st = (tok_q == TOK_OUT);
            ack_nx_o      = (plan_q == HS_ACK);
            cnt_load_o    = (plan_q == HS_ACK);
          end
        end
        S_WAIT_HACK: if (host_ack_i) begin
          state_d      = S_IDLE;
          ack_nx_o     = 1'b1;
          done_nx_o    = 1'b1;
          mark_o.in_st = 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      plan_q  <= HS_NONE;
      tok_q   <= TOK_NONE;
    end else begin
      state_q <= state_d;
      plan_q  <= plan_d;
      tok_q   <= tok_d;
    end
  end

  assign in_txn_o = (state_q != S_IDLE);

  assert_bad_pkt_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RX && tok_i == TOK_NONE && dend_i && !pkt_ok_i)
      |-> (hs_nx_o == HS_NONE && !done_nx_o && !cnt_load_o));

  assert_in_data_waits_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_nx_o |=> (state_q == S_WAIT_HACK));

  assert_setup_mark_needs_ctrl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o.setup_st |-> (tok_q == TOK_SETUP && plan_q == HS_ACK));
endmodule

// File: rtl/usb_ep_regs.sv
`timescale 1ns/1ps
module usb_ep_regs
  import usb_ep_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic              cpu_sel_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              ack_i,
  input  logic              cnt_load_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              rx_tog_i,
  input  pid_mark_t         mark_i,
  input  logic              in_txn_i,
  output logic [MODE_W-1:0] mode_o
);
  localparam int StLo    = MODE_W;
  localparam int LockBit = DATA_W - 1;
  localparam int DvalBit = DATA_W - 2;
  localparam int DtogBit = DATA_W - 1;

  logic [MODE_W-1:0] mode_q;
  pid_mark_t         st_q;
  logic              lock_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dval_q, dtog_q;
  logic              wr_mode, wr_cnt;
  logic              unused_wdata;

  assign wr_mode = cpu_we_i && !lock_q && (cpu_sel_i == SEL_MODE);
  assign wr_cnt  = cpu_we_i && !lock_q && (cpu_sel_i == SEL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      mode_q <= MODE_DIS;
    end else begin
      if (ack_i) lock_q <= 1'b1;
      else if (cpu_re_i && !in_txn_i) lock_q <= 1'b0;
      // hardware update wins over a same-cycle CPU write
      if (ack_i) mode_q <= MODE_NAK;
      else if (wr_mode) mode_q <= cpu_wdata_i[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      if (mark_i.setup_st) st_q.setup_st <= 1'b1;
      else if (wr_mode)    st_q.setup_st <= cpu_wdata_i[StLo];
      if (mark_i.in_st)    st_q.in_st    <= 1'b1;
      else if (wr_mode)    st_q.in_st    <= cpu_wdata_i[StLo+1];
      if (mark_i.out_st)   st_q.out_st   <= 1'b1;
      else if (wr_mode)    st_q.out_st   <= cpu_wdata_i[StLo+2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dval_q <= 1'b0;
      dtog_q <= 1'b0;
    end else if (cnt_load_i) begin
      cnt_q  <= rx_cnt_i;
      dval_q <= 1'b1;
      dtog_q <= rx_tog_i;
    end else if (wr_cnt) begin
      cnt_q  <= cpu_wdata_i[CNT_W-1:0];
      dval_q <= cpu_wdata_i[DvalBit];
      dtog_q <= cpu_wdata_i[DtogBit];
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    if (cpu_sel_i == SEL_MODE) begin
      cpu_rdata_o[MODE_W-1:0] = mode_q;
      cpu_rdata_o[StLo]       = st_q.setup_st;
      cpu_rdata_o[StLo+1]     = st_q.in_st;
      cpu_rdata_o[StLo+2]     = st_q.out_st;
      cpu_rdata_o[LockBit]    = lock_q;
    end else begin
      cpu_rdata_o[CNT_W-1:0]  = cnt_q;
      cpu_rdata_o[DvalBit]    = dval_q;
      cpu_rdata_o[DtogBit]    = dtog_q;
    end
  end

  assign mode_o       = mode_q;
  assign unused_wdata = ^cpu_wdata_i[DvalBit-1:CNT_W];

  assert_locked_write_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && cpu_we_i && !ack_i && !cnt_load_i)
      |=> ($stable(mode_q) && $stable(cnt_q) && $stable(dval_q) && $stable(dtog_q)));

  assert_ack_locks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (lock_q && mode_q == MODE_NAK));

  assert_txn_read_keeps_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && in_txn_i) |=> lock_q);

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_i |=> (cnt_q <= CNT_W'(MAX_BYTES) && dval_q));
endmodule

// File: rtl/usb_ep_responder.sv
`timescale 1ns/1ps
module usb_ep_responder
  import usb_ep_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        tok_pid_i,
  input  logic              data_start_i,
  input  logic              data_end_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              crc_ok_i,
  input  logic              pid_ok_i,
  input  logic              rx_tog_i,
  input  logic              host_ack_i,
  input  logic              buf_bad_i,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic              cpu_sel_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [1:0]        hs_o,
  output logic              tx_data_o,
  output logic              irq_o
);
  logic [MODE_W-1:0] mode;
  logic              pkt_ok, tx_nx, done_nx, ack_nx, cnt_load, in_txn;
  hs_e               hs_nx, hs_q;
  pid_mark_t         mark;
  logic              tx_q, irq_q;

  usb_ep_rxcheck #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) i_rxcheck (
    .cnt_i    (rx_cnt_i),
    .crc_ok_i (crc_ok_i),
    .pid_ok_i (pid_ok_i),
    .ok_o     (pkt_ok)
  );

  usb_ep_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tok_i      (tok_e'(tok_pid_i)),
    .dstart_i   (data_start_i),
    .dend_i     (data_end_i),
    .pkt_ok_i   (pkt_ok),
    .host_ack_i (host_ack_i),
    .mode_i     (mode),
    .hs_nx_o    (hs_nx),
    .tx_nx_o    (tx_nx),
    .done_nx_o  (done_nx),
    .ack_nx_o   (ack_nx),
    .cnt_load_o (cnt_load),
    .mark_o     (mark),
    .in_txn_o   (in_txn)
  );

  usb_ep_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_we_i    (cpu_we_i),
    .cpu_re_i    (cpu_re_i),
    .cpu_sel_i   (cpu_sel_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_rdata_o (cpu_rdata_o),
    .ack_i       (ack_nx),
    .cnt_load_i  (cnt_load),
    .rx_cnt_i    (rx_cnt_i),
    .rx_tog_i    (rx_tog_i),
    .mark_i      (mark),
    .in_txn_i    (in_txn),
    .mode_o      (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= HS_NONE;
      tx_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hs_q  <= hs_nx;
      tx_q  <= tx_nx;
      irq_q <= done_nx || buf_bad_i;
    end
  end

  assign hs_o      = hs_q;
  assign tx_data_o = tx_q;
  assign irq_o     = irq_q;

  assert_hs_raises_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_o != HS_NONE) |-> irq_o);

  assert_tx_excl_hs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_data_o |-> (hs_o == HS_NONE && !irq_o));

  assert_ignored_token_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_pid_i != 2'd0 && mode == MODE_DIS) |=> (hs_o == HS_NONE && !tx_data_o));
endmodule

// File: tb/test_usb_ep_responder.sv
`timescale 1ns/1ps
module test_usb_ep_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tok_pid = 2'd0;
  logic       dstart = 1'b0, dend = 1'b0;
  logic [3:0] rx_cnt = 4'd0;
  logic       crc_ok = 1'b0, pid_ok = 1'b0, rx_tog = 1'b0;
  logic       host_ack = 1'b0, buf_bad = 1'b0;
  logic       we = 1'b0, re = 1'b0, sel = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] hs;
  logic       tx, irq;

  int checks = 0;
  int errors = 0;
  logic [1:0] c_hs;
  logic       c_tx, c_irq;
  logic [7:0] rv;

  always #4 clk = ~clk;

  usb_ep_responder i_usb_ep_responder (
    .clk_i(clk), .rst_ni(rst_n), .tok_pid_i(tok_pid),
    .data_start_i(dstart), .data_end_i(dend), .rx_cnt_i(rx_cnt),
    .crc_ok_i(crc_ok), .pid_ok_i(pid_ok), .rx_tog_i(rx_tog),
    .host_ack_i(host_ack), .buf_bad_i(buf_bad),
    .cpu_we_i(we), .cpu_re_i(re), .cpu_sel_i(sel), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .hs_o(hs), .tx_data_o(tx), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic capture();
    c_hs = hs; c_tx = tx; c_irq = irq;
  endtask

  task automatic chk_ev(input string tag, input int e_hs, input int e_tx, input int e_irq);
    chk({tag, " hs"}, c_hs, e_hs);
    chk({tag, " tx"}, c_tx, e_tx);
    chk({tag, " irq"}, c_irq, e_irq);
  endtask

  task automatic send_tok(input logic [1:0] p);
    tok_pid = p; @(negedge clk); capture(); tok_pid = 2'd0;
  endtask

  task automatic data_begin();
    dstart = 1'b1; @(negedge clk); dstart = 1'b0;
  endtask

  task automatic data_finish(input logic [3:0] n, input logic c, input logic p, input logic t);
    rx_cnt = n; crc_ok = c; pid_ok = p; rx_tog = t; dend = 1'b1;
    @(negedge clk); capture(); dend = 1'b0;
  endtask

  task automatic send_data(input logic [3:0] n, input logic c, input logic p, input logic t);
    data_begin(); data_finish(n, c, p, t);
  endtask

  task automatic pulse_hack();
    host_ack = 1'b1; @(negedge clk); capture(); host_ack = 1'b0;
  endtask

  task automatic pulse_bad();
    buf_bad = 1'b1; @(negedge clk); capture(); buf_bad = 1'b0;
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    we = 1'b1; sel = s; wdata = d; @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    re = 1'b1; sel = s; #1 d = rdata; @(negedge clk); re = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hs", hs, 0); chk("R1 tx", tx, 0); chk("R1 irq", irq, 0);
    rd(1'b0, rv); chk("R1 mode reg", rv, 8'h00);
    rd(1'b1, rv); chk("R1 count reg", rv, 8'h00);
  endtask

  task automatic t_out_ack_lock();
    wr(1'b0, 8'h09);
    send_tok(2'd3); chk_ev("R5 out token alone", 0, 0, 0);
    send_data(4'd5, 1'b1, 1'b1, 1'b1); chk_ev("R5 out ack", 1, 0, 1);
    wr(1'b0, 8'h0D);
    wr(1'b1, 8'h00);
    rd(1'b0, rv); chk("R10 R9 R8 mode after ack", rv, 8'hC1);
    rd(1'b1, rv); chk("R8 count after ack", rv, 8'hC5);
    rd(1'b0, rv); chk("R11 unlocked after read", rv, 8'h41);
    wr(1'b0, 8'h09);
    rd(1'b0, rv); chk("R12 write after unlock", rv, 8'h09);
  endtask

  task automatic t_invalid();
    send_tok(2'd3); send_data(4'd11, 1'b1, 1'b1, 1'b0);
    chk_ev("R2 count 11", 0, 0, 0);
    send_tok(2'd3); send_data(4'd3, 1'b0, 1'b1, 1'b0);
    chk_ev("R2 bad crc", 0, 0, 0);
    send_tok(2'd3); send_data(4'd3, 1'b1, 1'b0, 1'b0);
    chk_ev("R2 bad pid", 0, 0, 0);
    rd(1'b1, rv); chk("R2 count unchanged", rv, 8'hC5);
    rd(1'b0, rv); chk("R2 mode unchanged", rv, 8'h09);
    send_tok(2'd3); send_data(4'd10, 1'b1, 1'b1, 1'b0);
    chk_ev("R2 count 10 accepted", 1, 0, 1);
    rd(1'b1, rv); chk("R8 count 10", rv, 8'h4A);
    rd(1'b0, rv); chk("R11 count read unlocks", rv, 8'h41);
  endtask

  task automatic t_direction();
    wr(1'b0, 8'h09);
    send_tok(2'd2); chk_ev("R4 in on out ep", 0, 0, 0);
    wr(1'b0, 8'h0D);
    send_tok(2'd3); send_data(4'd2, 1'b1, 1'b1, 1'b0);
    chk_ev("R4 out on in ep", 0, 0, 0);
    rd(1'b0, rv); chk("R4 in ep unchanged", rv, 8'h0D);
    send_tok(2'd2); chk_ev("R5 in data sent", 0, 1, 0);
    pulse_hack(); chk_ev("R6 in acked", 0, 0, 1);
    rd(1'b0, rv); chk("R9 R7 in ack locks", rv, 8'hA1);
    rd(1'b1, rv); chk("R8 in leaves count", rv, 8'h4A);
  endtask

  task automatic t_setup();
    wr(1'b0, 8'h09);
    send_tok(2'd1); data_begin();
    rd(1'b0, rv); chk("R3 setup ignored status", rv, 8'h09);
    data_finish(4'd8, 1'b1, 1'b1, 1'b0); chk_ev("R3 setup on out ep", 0, 0, 0);
    wr(1'b0, 8'h05);
    send_tok(2'd1); data_begin();
    rd(1'b0, rv); chk("R7 setup bit at data start", rv, 8'h15);
    data_finish(4'd8, 1'b1, 1'b1, 1'b0); chk_ev("R3 setup ack", 1, 0, 1);
    rd(1'b0, rv); chk("R8 R9 setup mode", rv, 8'h91);
    rd(1'b1, rv); chk("R8 setup count", rv, 8'h48);
  endtask

  task automatic t_read_in_txn();
    wr(1'b0, 8'h09);
    send_tok(2'd3); send_data(4'd1, 1'b1, 1'b1, 1'b1); chk_ev("R9 out ack", 1, 0, 1);
    send_tok(2'd3);
    rd(1'b0, rv); chk("R11 read in txn", rv, 8'hC1);
    send_data(4'd1, 1'b1, 1'b1, 1'b0); chk_ev("R5 out nak", 2, 0, 1);
    wr(1'b0, 8'h09);
    rd(1'b0, rv); chk("R11 still locked", rv, 8'hC1);
    rd(1'b1, rv); chk("R10 count kept", rv, 8'hC1);
    rd(1'b0, rv); chk("R11 released", rv, 8'h41);
  endtask

  task automatic t_stall_nak();
    wr(1'b0, 8'h03);
    send_tok(2'd2); chk_ev("R5 in stall", 3, 0, 1);
    send_tok(2'd3); send_data(4'd4, 1'b1, 1'b1, 1'b0); chk_ev("R5 out stall", 3, 0, 1);
    rd(1'b0, rv); chk("R7 stall status", rv, 8'h63);
    wr(1'b0, 8'h05);
    send_tok(2'd2); chk_ev("R5 ctrl in nak", 2, 0, 1);
    pulse_bad(); chk_ev("R6 buffer bad", 0, 0, 1);
    rd(1'b0, rv); chk("R6 regs after bad buf", rv, 8'h25);
  endtask

  task automatic t_disabled();
    wr(1'b0, 8'h00);
    send_tok(2'd2); chk_ev("R4 disabled in", 0, 0, 0);
    send_tok(2'd3); send_data(4'd2, 1'b1, 1'b1, 1'b0); chk_ev("R4 disabled out", 0, 0, 0);
    send_tok(2'd1); send_data(4'd2, 1'b1, 1'b1, 1'b0); chk_ev("R3 disabled setup", 0, 0, 0);
    rd(1'b0, rv); chk("R4 disabled regs", rv, 8'h00);
  endtask

  initial begin
    #100_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_out_ack_lock();
    t_invalid();
    t_direction();
    t_setup();
    t_read_in_txn();
    t_stall_nak();
    t_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule